// File: doc/BRIEF.md
# Split-Word SHA-512 Sigma Execution Unit

This unit sits in the execute stage of a 32-bit core. It evaluates the four SHA-512 mixing functions (two compression-round Sigma functions and two message-schedule sigma functions) when each 64-bit word of the hash state lives in a pair of 32-bit registers. Every instruction in the family returns one 32-bit slice of a 64-bit function. Software builds the full 64-bit answer from two instructions, swapping which register holds the low half.

On each accepted request the unit decodes the instruction word and joins the two operands into a 64-bit value X. The first operand forms bits 31:0 of X and the second operand forms bits 63:32. The unit then XORs three terms chosen by the operation and keeps bits 31:0 of that XOR. Two of the six operations are "high" forms. In these, the middle rotate term is replaced by a logical right shift of the first operand alone, zero-extended to 64 bits, so no bits of the second operand reach the result through that term.

The result appears one clock after the request, together with a decode-hit flag and an illegal flag. Register access, writeback and trap handling belong to the surrounding pipeline.

Top module: `sigsplit_top`

## Requirements
- R1: An instruction word is in the family only if bits 6:0 are 0110011, bits 14:12 are 000 and bits 31:30 are 01. Bits 29:25 then pick the operation: 01000 round-Sigma0, 01001 round-Sigma1, 01010 schedule-sigma0 low, 01011 schedule-sigma1 low, 01110 schedule-sigma0 high, 01111 schedule-sigma1 high. For a family word the match output is 1.
- R2: Round-Sigma0 returns bits 31:0 of rotl(X,25) ^ rotl(X,30) ^ rotr(X,28), where X = {second operand, first operand}.
- R3: Round-Sigma1 returns bits 31:0 of rotl(X,23) ^ rotr(X,14) ^ rotr(X,18).
- R4: Schedule-sigma0 low returns bits 31:0 of rotr(X,1) ^ rotr(X,7) ^ rotr(X,8).
- R5: Schedule-sigma1 low returns bits 31:0 of rotl(X,3) ^ rotr(X,6) ^ rotr(X,19).
- R6: Schedule-sigma0 high returns bits 31:0 of rotr(X,1) ^ ({32'b0, first operand} >> 7) ^ rotr(X,8).
- R7: Schedule-sigma1 high returns bits 31:0 of rotl(X,3) ^ ({32'b0, first operand} >> 6) ^ rotr(X,19).
- R8: When the enable input is 0, a family word gives match 1, illegal 1 and a result of zero.
- R9: A word outside the family gives match 0, illegal 0 and a result of zero.
- R10: Result, match and illegal are registered when in_valid is 1. out_valid is 1 in the cycle after each in_valid and 0 otherwise. The outputs hold their values while no request arrives. A synchronous active-high reset clears out_valid and the registered outputs.
- R11: Bits 24:15 and 11:7 of the instruction word (the register-number fields) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; the inputs below are sampled when it is 1 |
| insn | input | 32 | Instruction word |
| rs1_val | input | 32 | First operand, bits 31:0 of X |
| rs2_val | input | 32 | Second operand, bits 63:32 of X |
| hash_en | input | 1 | Extension enable; 0 makes family words illegal |
| out_valid | output | 1 | One-cycle strobe marking a response |
| out_data | output | 32 | Function result, zero for illegal or unmatched words |
| out_match | output | 1 | The word was in the family |
| out_illegal | output | 1 | The word matched, but the extension is disabled |

## Verification
Every response is due exactly one rising edge after the request it answers, because the decode and the XOR lanes are combinational and feed a single output register. The bench applies each request on a falling edge with in_valid high, and drops in_valid on the next falling edge. At that same falling edge it compares out_data, out_match, out_illegal and out_valid against a 64-bit rotate-and-shift model. One more falling edge later, with no request pending, it confirms that out_valid has fallen and that the data has held. Between checks, nothing is sampled near a rising edge.

// File: rtl/sigsplit_pkg.sv
package sigsplit_pkg;

    localparam int XW     = 32;
    localparam int WW     = 2 * XW;
    localparam int NUM_FN = 6;
    localparam int SW     = $clog2(WW);
    localparam int SELW   = 5;

    localparam logic [6:0] OPC_FAMILY = 7'b0110011;
    localparam logic [2:0] F3_FAMILY  = 3'b000;
    localparam logic [1:0] TOP_FAMILY = 2'b01;

    typedef enum logic [2:0] {
        FN_RSUM0  = 3'd0,
        FN_RSUM1  = 3'd1,
        FN_SSIG0L = 3'd2,
        FN_SSIG1L = 3'd3,
        FN_SSIG0H = 3'd4,
        FN_SSIG1H = 3'd5
    } fn_e;

    // All amounts are right-rotate distances; a left rotate by n is a right rotate by WW-n.
    typedef struct packed {
        logic [SW-1:0] rot_a;
        logic [SW-1:0] rot_b;
        logic [SW-1:0] rot_c;
        logic          mid_is_shift;
    } lane_cfg_t;

    typedef struct packed {
        logic match;
        logic illegal;
    } dec_t;

    typedef struct packed {
        logic          valid;
        logic          match;
        logic          illegal;
        logic [XW-1:0] data;
    } resp_t;

    function automatic lane_cfg_t lane_cfg(fn_e f);
        lane_cfg_t c;
        case (f)
            FN_RSUM0:  c = '{rot_a: SW'(WW-25), rot_b: SW'(WW-30), rot_c: SW'(28), mid_is_shift: 1'b0};
            FN_RSUM1:  c = '{rot_a: SW'(WW-23), rot_b: SW'(14),    rot_c: SW'(18), mid_is_shift: 1'b0};
            FN_SSIG0L: c = '{rot_a: SW'(1),     rot_b: SW'(7),     rot_c: SW'(8),  mid_is_shift: 1'b0};
            FN_SSIG1L: c = '{rot_a: SW'(WW-3),  rot_b: SW'(6),     rot_c: SW'(19), mid_is_shift: 1'b0};
            FN_SSIG0H: c = '{rot_a: SW'(1),     rot_b: SW'(7),     rot_c: SW'(8),  mid_is_shift: 1'b1};
            default:   c = '{rot_a: SW'(WW-3),  rot_b: SW'(6),     rot_c: SW'(19), mid_is_shift: 1'b1};
        endcase
        return c;
    endfunction

    function automatic logic [SELW-1:0] fn_code(fn_e f);
        case (f)
            FN_RSUM0:  return 5'b01000;
            FN_RSUM1:  return 5'b01001;
            FN_SSIG0L: return 5'b01010;
            FN_SSIG1L: return 5'b01011;
            FN_SSIG0H: return 5'b01110;
            default:   return 5'b01111;
        endcase
    endfunction

    function automatic logic [WW-1:0] rotr(logic [WW-1:0] v, int n);
        if (n == 0) return v;
        return (v >> n) | (v << (WW - n));
    endfunction

endpackage

// File: rtl/sigsplit_decode.sv
module sigsplit_decode
    import sigsplit_pkg::*;
#(
    parameter bit IS_RV32 = 1'b1
) (
    input  logic [XW-1:0]     insn,
    input  logic              hash_en,
    output logic [NUM_FN-1:0] hit,
    output dec_t              dec
);
    logic frame_ok;

    assign frame_ok = (insn[6:0] == OPC_FAMILY) &&
                      (insn[14:12] == F3_FAMILY) &&
                      (insn[31:30] == TOP_FAMILY);

    for (genvar i = 0; i < NUM_FN; i++) begin : g_hit
        assign hit[i] = frame_ok && (insn[29:25] == fn_code(fn_e'(i)));
    end

    always_comb begin
        dec.match   = |hit;
        dec.illegal = dec.match && !(IS_RV32 && hash_en);
    end
endmodule

// File: rtl/sigsplit_lanes.sv
module sigsplit_lanes
    import sigsplit_pkg::*;
(
    input  logic [WW-1:0]             x,
    input  logic [XW-1:0]             lo_word,
    output logic [NUM_FN-1:0][XW-1:0] lane
);
    for (genvar i = 0; i < NUM_FN; i++) begin : g_lane
        localparam lane_cfg_t C = lane_cfg(fn_e'(i));
        logic [WW-1:0] term_a, term_b, term_c, mix;

        assign term_a = rotr(x, int'(C.rot_a));
        assign term_c = rotr(x, int'(C.rot_c));
        if (C.mid_is_shift) begin : g_shift
            assign term_b = {{XW{1'b0}}, lo_word} >> C.rot_b;
        end else begin : g_rot
            assign term_b = rotr(x, int'(C.rot_b));
        end

        assign mix     = term_a ^ term_b ^ term_c;
        assign lane[i] = mix[XW-1:0];
    end
endmodule

// File: rtl/sigsplit_outreg.sv
module sigsplit_outreg
    import sigsplit_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  resp_t d,
    output resp_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= d.valid;
            if (d.valid) begin
                q.match   <= d.match;
                q.illegal <= d.illegal;
                q.data    <= d.data;
            end
        end
    end
endmodule

// File: rtl/sigsplit_top.sv
module sigsplit_top
    import sigsplit_pkg::*;
#(
    parameter bit IS_RV32 = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [31:0]   insn,
    input  logic [31:0]   rs1_val,
    input  logic [31:0]   rs2_val,
    input  logic          hash_en,
    output logic          out_valid,
    output logic [31:0]   out_data,
    output logic          out_match,
    output logic          out_illegal
);
    logic [NUM_FN-1:0]         hit;
    dec_t                      dec;
    logic [NUM_FN-1:0][XW-1:0] lane;
    resp_t                     nxt, cur;

    sigsplit_decode #(.IS_RV32(IS_RV32)) u_dec (
        .insn    (insn),
        .hash_en (hash_en),
        .hit     (hit),
        .dec     (dec)
    );

    sigsplit_lanes u_lanes (
        .x       ({rs2_val, rs1_val}),
        .lo_word (rs1_val),
        .lane    (lane)
    );

    always_comb begin
        nxt.valid   = in_valid;
        nxt.match   = dec.match;
        nxt.illegal = dec.illegal;
        nxt.data    = '0;
        if (!dec.illegal) begin
            for (int i = 0; i < NUM_FN; i++) begin
                nxt.data |= lane[i] & {XW{hit[i]}};
            end
        end
    end

    sigsplit_outreg u_oreg (
        .clk (clk),
        .rst (rst),
        .d   (nxt),
        .q   (cur)
    );

    assign out_valid   = cur.valid;
    assign out_data    = cur.data;
    assign out_match   = cur.match;
    assign out_illegal = cur.illegal;

    assert_onehot_hit_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> $onehot0(hit));

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drops_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(out_match) && $stable(out_illegal)));

    assert_illegal_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_match && out_data == '0));

    assert_disabled_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !hash_en) |=> (!out_match || out_illegal));

    assert_nomatch_clean_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_match) |-> (!out_illegal && out_data == '0));
endmodule

// File: tb/sim_sigsplit_top.sv
module sim_sigsplit_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] insn, rs1_val, rs2_val;
    logic        hash_en;
    logic        out_valid, out_match, out_illegal;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sigsplit_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .hash_en(hash_en),
        .out_valid(out_valid), .out_data(out_data),
        .out_match(out_match), .out_illegal(out_illegal)
    );

    function automatic logic [63:0] rl(logic [63:0] v, int n);
        return (v << n) | (v >> (64 - n));
    endfunction

    function automatic logic [63:0] rr(logic [63:0] v, int n);
        return (v >> n) | (v << (64 - n));
    endfunction

    function automatic logic [4:0] sel_of(int op);
        logic [4:0] s [6] = '{5'b01000, 5'b01001, 5'b01010, 5'b01011, 5'b01110, 5'b01111};
        return s[op];
    endfunction

    function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b);
        logic [63:0] x, r;
        x = {b, a};
        case (op)
            0: r = rl(x, 25) ^ rl(x, 30) ^ rr(x, 28);
            1: r = rl(x, 23) ^ rr(x, 14) ^ rr(x, 18);
            2: r = rr(x, 1) ^ rr(x, 7) ^ rr(x, 8);
            3: r = rl(x, 3) ^ rr(x, 6) ^ rr(x, 19);
            4: r = rr(x, 1) ^ ({32'b0, a} >> 7) ^ rr(x, 8);
            default: r = rl(x, 3) ^ ({32'b0, a} >> 6) ^ rr(x, 19);
        endcase
        return r[31:0];
    endfunction

    function automatic logic [31:0] enc(int op, logic [4:0] f2, logic [4:0] f1, logic [4:0] fd);
        return {2'b01, sel_of(op), f2, f1, 3'b000, fd, 7'b0110011};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one request at a falling edge; the response is read one falling edge later.
    task automatic issue(logic [31:0] w, logic [31:0] a, logic [31:0] b, logic en);
        @(negedge clk);
        insn = w; rs1_val = a; rs2_val = b; hash_en = en; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_op(int op, logic [31:0] a, logic [31:0] b);
        string tag;
        tag = (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 2) ? "R4" :
              (op == 3) ? "R5" : (op == 4) ? "R6" : "R7";
        issue(enc(op, 5'd3, 5'd9, 5'd17), a, b, 1'b1);
        check(tag, out_data, model(op, a, b));
        check("R1 match", {31'b0, out_match}, 32'd1);
        check("R1 illegal low", {31'b0, out_illegal}, 32'd0);
        check("R10 valid", {31'b0, out_valid}, 32'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; insn = '0; rs1_val = '0; rs2_val = '0; hash_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset valid", {31'b0, out_valid}, 32'd0);
        check("R10 reset data", out_data, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_corners();
        for (int op = 0; op < 6; op++) begin
            run_op(op, 32'h0, 32'h0);
            run_op(op, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
            run_op(op, 32'h0, 32'hFFFF_FFFF);
            run_op(op, 32'hFFFF_FFFF, 32'h0);
            for (int bitn = 0; bitn < 64; bitn++) begin
                logic [63:0] v;
                v = 64'd1 << bitn;
                run_op(op, v[31:0], v[63:32]);
            end
        end
    endtask

    task automatic t_random();
        for (int k = 0; k < 40; k++) begin
            for (int op = 0; op < 6; op++) begin
                run_op(op, $urandom, $urandom);
            end
        end
    endtask

    task automatic t_disabled();
        for (int op = 0; op < 6; op++) begin
            issue(enc(op, 5'd1, 5'd2, 5'd3), 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
            check("R8 match", {31'b0, out_match}, 32'd1);
            check("R8 illegal", {31'b0, out_illegal}, 32'd1);
            check("R8 data", out_data, 32'd0);
        end
    endtask

    task automatic t_nomatch();
        logic [31:0] good, bad [5];
        good   = enc(2, 5'd4, 5'd5, 5'd6);
        bad[0] = {good[31:7], 7'b0010011};
        bad[1] = {good[31:15], 3'b001, good[11:0]};
        bad[2] = {2'b00, good[29:0]};
        bad[3] = {good[31:30], 5'b01100, good[24:0]};
        bad[4] = {2'b11, good[29:0]};
        for (int k = 0; k < 5; k++) begin
            issue(bad[k], 32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1);
            check("R9 match", {31'b0, out_match}, 32'd0);
            check("R9 illegal", {31'b0, out_illegal}, 32'd0);
            check("R9 data", out_data, 32'd0);
        end
    endtask

    task automatic t_fields();
        logic [31:0] a, b;
        a = 32'h0F1E_2D3C; b = 32'h4B5A_6978;
        for (int op = 0; op < 6; op++) begin
            issue(enc(op, 5'd31, 5'd0, 5'd31), a, b, 1'b1);
            check("R11 fields", out_data, model(op, a, b));
            issue(enc(op, 5'd10, 5'd21, 5'd0), a, b, 1'b1);
            check("R11 fields", out_data, model(op, a, b));
        end
    endtask

    task automatic t_timing();
        logic [31:0] exp;
        exp = model(5, 32'h8000_0001, 32'h7FFF_FFFE);
        issue(enc(5, 5'd1, 5'd1, 5'd1), 32'h8000_0001, 32'h7FFF_FFFE, 1'b1);
        check("R10 valid pulse", {31'b0, out_valid}, 32'd1);
        insn = '0; rs1_val = $urandom; rs2_val = $urandom;
        @(negedge clk);
        check("R10 valid falls", {31'b0, out_valid}, 32'd0);
        check("R10 hold", out_data, exp);
        check("R10 hold match", {31'b0, out_match}, 32'd1);
        // back-to-back requests
        @(negedge clk);
        insn = enc(0, 5'd1, 5'd1, 5'd1); rs1_val = 32'h1; rs2_val = 32'h0; hash_en = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R10 b2b first", out_data, model(0, 32'h1, 32'h0));
        insn = enc(1, 5'd1, 5'd1, 5'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 b2b second", out_data, model(1, 32'h1, 32'h0));
        check("R10 b2b valid", {31'b0, out_valid}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_corners();
        t_random();
        t_disabled();
        t_nomatch();
        t_fields();
        t_timing();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule